// File: doc/BRIEF.md
# Low-Speed USB Packet Transmitter

This block puts one low-speed USB packet onto the D+ and D- lines. A start strobe launches a transfer. The block first drives the bus to the idle J level with its drivers still off, then turns the drivers on. It sends the sync byte and the payload bytes, least significant bit first, with NRZI coding and bit stuffing. It finishes with the end-of-packet sequence, releases the bus and raises a one-clock done pulse. Payload bytes come from an external buffer through an address output and a data input that is read in the same clock.

A second kind of request sends a handshake packet. It is two bytes long, sync followed by an ACK or NAK PID, and it needs no buffer access. The block also holds the device address register. A pending address presented at its input is copied into that register when a data packet ends, and never when a handshake ends.

The bit period is a parameter counted in clock cycles. At a 48 MHz clock the default of 32 gives 1.5 Mbit/s, well inside the tolerance that low-speed signalling allows.

Top module: `usb_ls_tx`

## Requirements
- R1: After reset, oe, dp, dm and done are 0 and dev_addr is 0.
- R2: On an accepted start, the next clock shows dp=0, dm=1 (J) with oe still 0. In the clock after that, oe goes to 1 and J is driven for one bit time (CLK_PER_BIT clocks) before the first sync bit.
- R3: The packet bits are the sync byte 0x80 followed by the payload bytes read from rd_data at rd_addr 0, 1, ... byte_cnt-2. Each byte is sent least significant bit first and each bit lasts CLK_PER_BIT clocks.
- R4: NRZI coding: a 0 bit switches the lines between J (dp=0, dm=1) and K (dp=1, dm=0), and a 1 bit keeps the current level. dp and dm are never both 1.
- R5: After six consecutive 1 bits, an extra 0 bit is inserted, including after the final data bit. The run count starts at zero at the start of sync.
- R6: byte_cnt counts the sync byte. A data start is accepted only when byte_cnt lies between 2 and 12. Any other value is ignored, and oe and dm stay 0.
- R7: A start with hs_req=1 sends exactly sync plus one PID, whatever byte_cnt is. The PID is ACK 0xD2 when hs_nak=0 and NAK 0x5A when hs_nak=1.
- R8: After the last bit, both lines are low (SE0) for two bit times, then J for one bit time. Then oe, dp and dm all go to 0.
- R9: done is 1 for exactly one clock, the first clock in which oe is 0 again.
- R10: When a data packet ends, dev_addr takes the value of addr_pend. A handshake leaves dev_addr unchanged.
- R11: A start that arrives while a packet is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, acted on only when idle |
| hs_req | input | 1 | 1 selects a handshake packet instead of buffer data |
| hs_nak | input | 1 | Handshake PID select: 0 ACK, 1 NAK |
| byte_cnt | input | CNT_W | Packet length in bytes, sync included |
| rd_addr | output | RA_W | Index of the payload byte being fetched |
| rd_data | input | 8 | Payload byte at rd_addr, valid in the same clock |
| addr_pend | input | ADDR_W | Address to commit at the end of a data packet |
| dev_addr | output | ADDR_W | Active device address register |
| dp | output | 1 | D+ drive value |
| dm | output | 1 | D- drive value |
| oe | output | 1 | Line driver enable |
| done | output | 1 | One-clock pulse after the bus is released |

## Verification
Each packet's line levels are sampled in the middle of every bit slot and compared with a stream that the bench builds from the bytes. A payload with no long runs of 1 bits confirms plain NRZI and bit order. Runs of 0xF0 followed by 0xFF place stuffed bits both inside the packet and directly after the final data bit, which separates correct stuffing from stuffing that stops at the byte boundary. The longest and shortest valid lengths, two out-of-range lengths, ACK and NAK handshakes with a misleading byte_cnt, and a start pulsed in the middle of a packet each confirm the length, PID selection, ignore rules and address commit.

// File: rtl/usb_ls_tx_pkg.sv
package usb_ls_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_SEND,
    ST_SE0,
    ST_JEND
  } tx_state_t;

  localparam logic [7:0] SYNC_BYTE = 8'h80;
  localparam logic [7:0] PID_ACK   = 8'hD2;
  localparam logic [7:0] PID_NAK   = 8'h5A;

endpackage

// File: rtl/usb_ls_tx_baud.sv
module usb_ls_tx_baud #(
  parameter int CLK_PER_BIT = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);

  localparam int TW = $clog2(CLK_PER_BIT + 1);
  localparam logic [TW-1:0] LAST = TW'(CLK_PER_BIT - 1);

  logic [TW-1:0] cnt_q;

  always_comb tick = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  // R3
  period_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

endmodule

// File: rtl/usb_ls_tx_enc.sv
module usb_ls_tx_enc #(
  parameter int STUFF_RUN = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       init,
  input  logic       tick,
  input  logic       nxt_avail,
  input  logic [7:0] nxt_data,
  output logic       toggle,
  output logic       take,
  output logic       fin
);
  import usb_ls_tx_pkg::*;

  localparam int OW = $clog2(STUFF_RUN + 1);
  localparam logic [OW-1:0] RUN_MAX = OW'(STUFF_RUN);

  logic [7:0]    sh_q;
  logic [2:0]    bidx_q;
  logic [OW-1:0] ones_q;
  logic          last_q;
  logic          stuff;

  always_comb begin
    stuff  = (ones_q == RUN_MAX);
    toggle = tick && (stuff || (!last_q && !sh_q[0]));
    fin    = tick && !stuff && last_q;
    take   = tick && !stuff && !last_q && (bidx_q == 3'd7) && nxt_avail;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      bidx_q <= '0;
      ones_q <= '0;
      last_q <= 1'b0;
    end else if (init) begin
      sh_q   <= SYNC_BYTE;
      bidx_q <= '0;
      ones_q <= '0;
      last_q <= 1'b0;
    end else if (tick) begin
      if (stuff) begin
        ones_q <= '0;
      end else if (!last_q) begin
        ones_q <= sh_q[0] ? ones_q + 1'b1 : '0;
        if (bidx_q == 3'd7) begin
          bidx_q <= '0;
          if (nxt_avail) sh_q   <= nxt_data;
          else           last_q <= 1'b1;
        end else begin
          sh_q   <= sh_q >> 1;
          bidx_q <= bidx_q + 1'b1;
        end
      end
    end
  end

  // R5
  run_limit_chk: assert property (@(posedge clk) disable iff (rst)
    ones_q <= RUN_MAX);

  // R5
  stuff_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !init && ones_q == RUN_MAX) |=> (ones_q == '0));

endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx #(
  parameter int CLK_PER_BIT = 32,
  parameter int MAX_BYTES   = 12,
  parameter int MIN_BYTES   = 2,
  parameter int ADDR_W      = 7,
  localparam int CNT_W      = $clog2(MAX_BYTES + 1),
  localparam int RA_W       = $clog2(MAX_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              hs_req,
  input  logic              hs_nak,
  input  logic [CNT_W-1:0]  byte_cnt,
  output logic [RA_W-1:0]   rd_addr,
  input  logic [7:0]        rd_data,
  input  logic [ADDR_W-1:0] addr_pend,
  output logic [ADDR_W-1:0] dev_addr,
  output logic              dp,
  output logic              dm,
  output logic              oe,
  output logic              done
);
  import usb_ls_tx_pkg::*;

  tx_state_t  state_q;
  logic       hs_q, nak_q, eop_ph_q;
  logic [CNT_W-1:0] rem_q;
  logic       run, tick, toggle, take, fin, cnt_ok;
  logic [7:0] nxt_data;

  always_comb begin
    run      = (state_q == ST_SEND) || (state_q == ST_SE0) || (state_q == ST_JEND);
    cnt_ok   = (byte_cnt >= CNT_W'(MIN_BYTES)) && (byte_cnt <= CNT_W'(MAX_BYTES));
    nxt_data = hs_q ? (nak_q ? PID_NAK : PID_ACK) : rd_data;
  end

  usb_ls_tx_baud #(.CLK_PER_BIT(CLK_PER_BIT)) u_baud (
    .clk (clk),
    .rst (rst),
    .run (run),
    .tick(tick)
  );

  usb_ls_tx_enc #(.STUFF_RUN(6)) u_enc (
    .clk      (clk),
    .rst      (rst),
    .init     (state_q == ST_ARM),
    .tick     (tick && state_q == ST_SEND),
    .nxt_avail(rem_q != '0),
    .nxt_data (nxt_data),
    .toggle   (toggle),
    .take     (take),
    .fin      (fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      dp       <= 1'b0;
      dm       <= 1'b0;
      oe       <= 1'b0;
      done     <= 1'b0;
      hs_q     <= 1'b0;
      nak_q    <= 1'b0;
      eop_ph_q <= 1'b0;
      rem_q    <= '0;
      rd_addr  <= '0;
      dev_addr <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start && (hs_req || cnt_ok)) begin
            state_q <= ST_ARM;
            dp      <= 1'b0;
            dm      <= 1'b1;
            hs_q    <= hs_req;
            nak_q   <= hs_nak;
            rem_q   <= hs_req ? CNT_W'(1) : byte_cnt - 1'b1;
            rd_addr <= '0;
          end
        end
        ST_ARM: begin
          oe      <= 1'b1;
          state_q <= ST_SEND;
        end
        ST_SEND: begin
          if (fin) begin
            dp       <= 1'b0;
            dm       <= 1'b0;
            eop_ph_q <= 1'b0;
            state_q  <= ST_SE0;
          end else if (toggle) begin
            dp <= ~dp;
            dm <= ~dm;
          end
          if (take) begin
            rem_q <= rem_q - 1'b1;
            if (!hs_q) rd_addr <= rd_addr + 1'b1;
          end
        end
        ST_SE0: begin
          if (tick) begin
            if (eop_ph_q) begin
              dm      <= 1'b1;
              state_q <= ST_JEND;
            end else begin
              eop_ph_q <= 1'b1;
            end
          end
        end
        ST_JEND: begin
          if (tick) begin
            oe      <= 1'b0;
            dp      <= 1'b0;
            dm      <= 1'b0;
            done    <= 1'b1;
            state_q <= ST_IDLE;
            if (!hs_q) dev_addr <= addr_pend;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4
  lines_legal_chk: assert property (@(posedge clk) disable iff (rst)
    oe |-> !(dp && dm));

  // R2
  enable_at_j_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(oe) |-> (!dp && dm));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  done_release_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!oe && $past(oe)));

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(dev_addr));

endmodule

// File: tb/usb_ls_tx_tb.sv
`timescale 1ns/1ps
module usb_ls_tx_tb;

  localparam int P = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       hs_req = 1'b0;
  logic       hs_nak = 1'b0;
  logic [3:0] byte_cnt = 4'd0;
  logic [3:0] rd_addr;
  logic [7:0] rd_data;
  logic [6:0] addr_pend = 7'd0;
  logic [6:0] dev_addr;
  logic       dp, dm, oe, done;

  logic [7:0] mem [0:11];
  logic       exp_lv [0:127];
  int         exp_n;
  int         checks = 0;
  int         errors = 0;
  bit         finished = 0;

  always #2 clk = ~clk;

  assign rd_data = mem[rd_addr];

  usb_ls_tx #(.CLK_PER_BIT(P)) u_dut (
    .clk(clk), .rst(rst), .start(start), .hs_req(hs_req), .hs_nak(hs_nak),
    .byte_cnt(byte_cnt), .rd_addr(rd_addr), .rd_data(rd_data),
    .addr_pend(addr_pend), .dev_addr(dev_addr),
    .dp(dp), .dm(dm), .oe(oe), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic build_stream(input bit hs, input bit nak, input int nb);
    logic lv;
    int   ones;
    logic [7:0] b;
    lv = 1'b0; ones = 0; exp_n = 0;
    for (int k = 0; k < nb; k++) begin
      if (k == 0)  b = 8'h80;
      else if (hs) b = nak ? 8'h5A : 8'hD2;
      else         b = mem[k-1];
      for (int i = 0; i < 8; i++) begin
        if (!b[i]) begin lv = ~lv; ones = 0; end
        else ones++;
        exp_lv[exp_n] = lv; exp_n++;
        if (ones == 6) begin
          lv = ~lv; ones = 0;
          exp_lv[exp_n] = lv; exp_n++;
        end
      end
    end
  endtask

  task automatic run_pkt(input bit hs, input bit nak, input int cnt,
                         input bit poke, input logic [6:0] pend, input string name);
    int t, mis, first_s, nb;
    logic edp, edm;
    logic [6:0] exp_addr;
    nb = hs ? 2 : cnt;
    build_stream(hs, nak, nb);
    exp_addr = hs ? dev_addr : pend;
    @(negedge clk);
    addr_pend = pend; hs_req = hs; hs_nak = nak; byte_cnt = 4'(cnt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!oe && !dp && dm, "R2", {name, " J set before enable"}, {oe, dp, dm}, 3'b001);
    @(negedge clk);
    check(oe && !dp && dm, "R2", {name, " enable at J"}, {oe, dp, dm}, 3'b101);
    t = 0; mis = 0; first_s = -1;
    for (int s = 0; s < exp_n + 4; s++) begin
      while (t < s * P + P / 2) begin @(negedge clk); t++; end
      if (s == 0 || s == exp_n + 3) begin edp = 1'b0; edm = 1'b1; end
      else if (s > exp_n)           begin edp = 1'b0; edm = 1'b0; end
      else begin edp = exp_lv[s-1]; edm = ~exp_lv[s-1]; end
      if (!(oe && dp == edp && dm == edm)) begin
        mis++;
        if (first_s < 0) first_s = s;
      end
      if (poke && s == 3) begin
        byte_cnt = 4'd12; hs_req = 1'b0; start = 1'b1;
        @(negedge clk); t++;
        start = 1'b0;
      end
    end
    check(mis == 0, "R3 R4 R5 R8", {name, " line stream mismatches (first slot)"},
          mis == 0 ? 0 : first_s, 0);
    while (t < (exp_n + 4) * P) begin @(negedge clk); t++; end
    check(!oe && !dp && !dm, "R8", {name, " bus released"}, {oe, dp, dm}, 0);
    check(done, "R9", {name, " done at release"}, done, 1);
    @(negedge clk);
    check(!done && !oe, "R9", {name, " done one clock"}, {done, oe}, 0);
    check(dev_addr == exp_addr, "R10", {name, " device address"}, dev_addr, exp_addr);
    if (poke) begin
      for (int i = 0; i < 4 * P; i++) begin
        @(negedge clk);
        if (oe || dm) mis++;
      end
      check(mis == 0, "R11", {name, " no packet from start while busy"}, mis, 0);
    end
  endtask

  task automatic run_bad(input int cnt);
    int seen;
    seen = 0;
    @(negedge clk);
    hs_req = 1'b0; byte_cnt = 4'(cnt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 4 * P; i++) begin
      if (oe || dm || done) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R6", $sformatf("byte_cnt %0d ignored", cnt), seen, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!oe && !dp && !dm && !done, "R1", "outputs after reset", {oe, dp, dm, done}, 0);
    check(dev_addr == 7'd0, "R1", "dev_addr after reset", dev_addr, 0);

    mem[0] = 8'h3C; mem[1] = 8'hA5; mem[2] = 8'h00;
    run_pkt(1'b0, 1'b0, 4, 1'b0, 7'h15, "R3 plain data");

    mem[0] = 8'hF0; mem[1] = 8'hFF;
    run_pkt(1'b0, 1'b0, 3, 1'b0, 7'h2A, "R5 stuffing incl. after last bit");

    for (int i = 0; i < 11; i++) mem[i] = 8'((i * 37 + 11) ^ (i << 4));
    run_pkt(1'b0, 1'b0, 12, 1'b0, 7'h41, "R6 max length");

    mem[0] = 8'h7F;
    run_pkt(1'b0, 1'b0, 2, 1'b0, 7'h07, "R6 min length");

    run_pkt(1'b1, 1'b0, 7, 1'b0, 7'h55, "R7 ACK handshake");
    run_pkt(1'b1, 1'b1, 9, 1'b0, 7'h66, "R7 NAK handshake");

    run_bad(1);
    run_bad(13);

    mem[0] = 8'hFF; mem[1] = 8'h01; mem[2] = 8'hFE; mem[3] = 8'h80;
    run_pkt(1'b0, 1'b0, 5, 1'b1, 7'h33, "R11 start while busy");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired: actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule